// File: doc/BRIEF.md
# Glitch-Free Clock Stop Controller

This block gates a set of clock lanes: CPU, SDRAM, gated PCI, one free-running PCI lane, reference and peripheral lanes, and 48/24 MHz lanes. Each lane has its own enable bit from a control register block. Two active-low stop inputs and an active-low power-down input also act on the lanes. A lane starts or stops only at a point where it cannot produce a short or clipped pulse. Every source clock is a plain digital input. The block samples each source on a fast system clock `clk`, and each gated output is a registered copy of its sampled source.

A mode strap decides what the two shared pins are. With the strap low, the pins are stop inputs. With the strap high, they are the top two SDRAM clock outputs, and the block drives their output-enable signals. Pins left unconnected in the system must read as 1; the pull-ups are outside this block. There is no streaming interface. All pins are plain level controls.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_n is low, every clk_out bit, both shr_out bits, both shr_oe bits and osc_on are 0.
- R2: A lane that is stopped holds its clk_out bit at 0 for as long as it stays stopped. A lane never stops in the high state.
- R3: A start or stop takes effect only after two events, in this order: a rising edge of the sampled pci_src, then a later falling edge of the lane's own sampled source. As a result, every high pulse on clk_out lasts exactly one full high phase of the lane's source, whether the lane is running, starting or stopping.
- R4: A lane runs only when its lane_en bit is 1 AND its stop condition allows it. lane_en, strap_sdr, shr_in and pwr_dn_n each pass through a two-flop synchronizer before they act.
- R5: With strap_sdr = 1, shr_oe = 2'b11. shr_out[0] carries SDRAM lane N_SDR-1 (lane 11 by default) and shr_out[1] carries SDRAM lane N_SDR-2 (lane 10). shr_in is ignored, so both stops count as released.
- R6: With strap_sdr = 0, shr_oe = 2'b00 and shr_out = 2'b00. shr_in[0] is an active-low PCI stop and shr_in[1] is an active-low CPU stop. The two SDRAM lanes that share the pins stay stopped.
- R7: A CPU stop (strap low, shr_in[1] = 0) stops the CPU lanes only. The SDRAM lanes keep running.
- R8: A PCI stop (strap low, shr_in[0] = 0) stops the gated PCI lanes. The free-running PCI lane (lane N_CPU+N_SDR+N_PCI, 18 by default) keeps running.
- R9: pwr_dn_n = 0 forces every clk_out bit to 0, the free-running PCI lane included, and drives osc_on to 0. When pwr_dn_n returns to 1, the lanes run again according to their enables.
- R10: A request that changes while a lane's transition is pending is ignored until that transition completes, and is then evaluated again. A one-cycle dip of an enable therefore gives a complete stop followed by a complete restart.
- R11: Lane order from bit 0 is: N_CPU CPU lanes (source cpu_src), N_SDR SDRAM lanes (sdr_src), N_PCI gated PCI lanes (pci_src), one free-running PCI lane (pci_src), N_XT reference/peripheral lanes (xt_src), and N_USB 48/24 MHz lanes (usb_src). lane_en and clk_out use this same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the whole block |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Source clock for the CPU lanes |
| sdr_src | input | 1 | Source clock for the SDRAM lanes |
| pci_src | input | 1 | Free-running PCI source; also the reference for every transition |
| xt_src | input | 1 | Source clock for the reference/peripheral lanes |
| usb_src | input | 1 | Source clock for the 48/24 MHz lanes |
| lane_en | input | NL | Per-lane enable bits from the register block, 1 = run |
| strap_sdr | input | 1 | Mode strap: 1 = shared pins are SDRAM outputs, 0 = stop inputs |
| pwr_dn_n | input | 1 | Active-low power-down |
| shr_in | input | 2 | Shared-pin input levels: [0] PCI stop, [1] CPU stop, both active low |
| clk_out | output | NL | Gated clock lanes |
| shr_out | output | 2 | Shared-pin clock drive: [0] SDRAM lane N_SDR-1, [1] SDRAM lane N_SDR-2 |
| shr_oe | output | 2 | Shared-pin output enables |
| osc_on | output | 1 | Oscillator and PLL run indicator, 0 while powered down |

## Verification
The assertions assume that every source input is stable around the rising edge of `clk`. They also assume that each source phase, high and low, lasts at least one sampling cycle, so that the sampled level and its detected edges are meaningful. The stimulus meets this by deriving all five sources from `clk`: each source is toggled on the falling edge of `clk` with half-periods of 2 to 6 cycles. All control inputs are changed on falling edges as well. Power-down is the only condition allowed to clip a pulse. The pulse-width monitor is switched off around it and re-arms only on a clean low level.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
  // Lane sequencing states; RUN and STOP are the settled ones.
  typedef enum logic [1:0] {
    L_STOP  = 2'd0,
    L_WREF  = 2'd1,
    L_WFALL = 2'd2,
    L_RUN   = 2'd3
  } lane_st_e;

  localparam int N_SRC = 5;  // cpu, sdram, pci, xtal, usb
  localparam int SRC_PCI = 2;
endpackage

// File: rtl/cs_sync2.sv
module cs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/cs_edge.sv
module cs_edge #(
  parameter int W    = 1,
  parameter int RIDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  output logic [W-1:0] lvl,
  output logic [W-1:0] fall,
  output logic         ref_rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl  <= '0;
      prev <= '0;
    end else begin
      lvl  <= src;
      prev <= lvl;
    end
  end

  assign fall     = prev & ~lvl;
  assign ref_rise = lvl[RIDX] & ~prev[RIDX];
endmodule

// File: rtl/cs_lane.sv
module cs_lane
  import clkstop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic want,
  input  logic ref_rise,
  input  logic src_lvl,
  input  logic src_fall,
  input  logic pwr_ok,
  output logic clk_o
);
  lane_st_e st, st_n;
  logic     tgt, tgt_n;
  logic     gate;

  // While a transition is pending the old gate value (the inverse of the target) holds.
  assign gate = (st == L_RUN) | ((st != L_STOP) & ~tgt);

  always_comb begin
    st_n  = st;
    tgt_n = tgt;
    case (st)
      L_RUN:   if (!want) begin st_n = L_WREF; tgt_n = 1'b0; end
      L_STOP:  if (want)  begin st_n = L_WREF; tgt_n = 1'b1; end
      L_WREF:  if (ref_rise) st_n = L_WFALL;
      L_WFALL: if (src_fall) st_n = tgt ? L_RUN : L_STOP;
      default: st_n = L_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= L_STOP;
      tgt   <= 1'b0;
      clk_o <= 1'b0;
    end else begin
      st    <= st_n;
      tgt   <= tgt_n;
      clk_o <= pwr_ok & src_lvl & gate;
    end
  end

  // R2: a settled stop yields a low output
  a_r2_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
    (st == L_STOP) |=> !clk_o);

  // R3: the gate moves only right after a falling edge of the lane's source
  a_r3_gate_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (gate != $past(gate)) |-> $past(src_fall));

  // R3: the fall wait starts only after a reference rising edge
  a_r3_ref_first: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == L_WFALL) && ($past(st) != L_WFALL)) |-> $past(ref_rise));

  // R3: an output high phase ends only with its source or with power-down
  a_r3_no_clipped_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_o) |-> (!$past(src_lvl) || !$past(pwr_ok)));
endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl
  import clkstop_pkg::*;
#(
  parameter  int N_CPU = 4,
  parameter  int N_SDR = 8,
  parameter  int N_PCI = 6,
  parameter  int N_XT  = 4,
  parameter  int N_USB = 2,
  localparam int NL    = N_CPU + N_SDR + N_PCI + 1 + N_XT + N_USB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_src,
  input  logic          sdr_src,
  input  logic          pci_src,
  input  logic          xt_src,
  input  logic          usb_src,
  input  logic [NL-1:0] lane_en,
  input  logic          strap_sdr,
  input  logic          pwr_dn_n,
  input  logic [1:0]    shr_in,
  output logic [NL-1:0] clk_out,
  output logic [1:0]    shr_out,
  output logic [1:0]    shr_oe,
  output logic          osc_on
);
  localparam int O_SDR  = N_CPU;
  localparam int O_PCI  = O_SDR + N_SDR;
  localparam int O_PCIF = O_PCI + N_PCI;
  localparam int O_XT   = O_PCIF + 1;
  localparam int O_USB  = O_XT + N_XT;
  localparam int SH_HI  = O_SDR + N_SDR - 1;  // shares pin 0
  localparam int SH_LO  = O_SDR + N_SDR - 2;  // shares pin 1

  logic [NL-1:0]    en_s;
  logic [1:0]       shr_s;
  logic             strap_s, pwr_s;
  logic [N_SRC-1:0] lvl, fall;
  logic             ref_rise;
  logic             cpu_ok, pci_ok;

  cs_sync2 #(.W(NL + 4)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({pwr_dn_n, strap_sdr, shr_in, lane_en}),
    .q    ({pwr_s, strap_s, shr_s, en_s})
  );

  cs_edge #(.W(N_SRC), .RIDX(SRC_PCI)) u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .src     ({usb_src, xt_src, pci_src, sdr_src, cpu_src}),
    .lvl     (lvl),
    .fall    (fall),
    .ref_rise(ref_rise)
  );

  // Stops are only meaningful when the shared pins are inputs.
  assign cpu_ok = strap_s | shr_s[1];
  assign pci_ok = strap_s | shr_s[0];

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam int SI = (i < O_SDR) ? 0 : (i < O_PCI) ? 1 :
                        (i < O_XT)  ? 2 : (i < O_USB) ? 3 : 4;
    logic want;
    if (i < O_SDR) begin : g_w
      assign want = en_s[i] & cpu_ok;
    end else if (i >= SH_LO && i < O_PCI) begin : g_w
      assign want = en_s[i] & strap_s;
    end else if (i >= O_PCI && i < O_PCIF) begin : g_w
      assign want = en_s[i] & pci_ok;
    end else begin : g_w
      assign want = en_s[i];
    end

    cs_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .want    (want),
      .ref_rise(ref_rise),
      .src_lvl (lvl[SI]),
      .src_fall(fall[SI]),
      .pwr_ok  (pwr_s),
      .clk_o   (clk_out[i])
    );
  end

  assign shr_oe  = {2{strap_s}};
  assign shr_out = strap_s ? {clk_out[SH_LO], clk_out[SH_HI]} : 2'b00;
  assign osc_on  = pwr_s;

  // R9: power-down clears every lane on the following cycle
  a_r9_pwr_all_low: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_s |=> (clk_out == '0));

  // R6: with the strap low the shared pins never drive
  a_r6_pins_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_s |-> (shr_out == 2'b00 && shr_oe == 2'b00));
endmodule

// File: tb/sim_clk_stop_ctrl.sv
module sim_clk_stop_ctrl;
  localparam int NL = 25, SDR6 = 10, SDR7 = 11, WIN = 60, SETTLE = 40;

  typedef struct {
    logic [NL-1:0] run;
    logic [1:0]    oe;
    logic [1:0]    srun;
    logic          osc;
    string         tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] srcv = '0;
  logic [NL-1:0] lane_en = '1;
  logic strap = 1'b1, pwr_n = 1'b1;
  logic [1:0] shr_in = 2'b11;
  logic [NL-1:0] clk_out;
  logic [1:0] shr_out, shr_oe;
  logic osc_on;
  int n_cmp = 0, n_bad = 0;
  bit pulse_chk = 1'b0;
  exp_t sb[$];
  int cnt[5] = '{default: 0};
  int half_g[5] = '{2, 3, 4, 5, 6};
  int hi_run[NL] = '{default: 0};
  bit armed[NL] = '{default: 1'b0};

  clk_stop_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .cpu_src(srcv[0]), .sdr_src(srcv[1]), .pci_src(srcv[2]),
    .xt_src(srcv[3]), .usb_src(srcv[4]),
    .lane_en(lane_en), .strap_sdr(strap), .pwr_dn_n(pwr_n), .shr_in(shr_in),
    .clk_out(clk_out), .shr_out(shr_out), .shr_oe(shr_oe), .osc_on(osc_on)
  );

  always #10 clk = ~clk;

  // Source dividers, toggled away from the sampling edge.
  always @(negedge clk)
    for (int g = 0; g < 5; g++) begin
      if (cnt[g] == half_g[g] - 1) begin cnt[g] = 0; srcv[g] = ~srcv[g]; end
      else cnt[g] = cnt[g] + 1;
    end

  function automatic int half_of(int i);
    if (i < 4) return 2;
    if (i < 12) return 3;
    if (i < 19) return 4;
    if (i < 23) return 5;
    return 6;
  endfunction

  task automatic check(bit ok, string what, logic [NL-1:0] act, logic [NL-1:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Expected lane activity straight from R4..R9 and R11.
  function automatic exp_t predict(string tag);
    exp_t e;
    logic w, cpu_ok, pci_ok;
    cpu_ok = strap | shr_in[1];
    pci_ok = strap | shr_in[0];
    for (int i = 0; i < NL; i++) begin
      w = lane_en[i];
      if (i < 4) w = w & cpu_ok;
      else if (i == SDR6 || i == SDR7) w = w & strap;
      else if (i >= 12 && i < 18) w = w & pci_ok;
      e.run[i] = w & pwr_n;
    end
    e.oe   = {2{strap}};
    e.srun = strap ? {e.run[SDR6], e.run[SDR7]} : 2'b00;
    e.osc  = pwr_n;
    e.tag  = tag;
    return e;
  endfunction

  task automatic settle_and_expect(string tag);
    repeat (SETTLE) @(negedge clk);
    sb.push_back(predict(tag));
    repeat (WIN + 3) @(negedge clk);
  endtask

  // R3 monitor: each high pulse lasts one whole source high phase.
  always @(negedge clk)
    for (int i = 0; i < NL; i++) begin
      if (!pulse_chk) begin
        hi_run[i] = 0;
        armed[i]  = 1'b0;
      end else if (clk_out[i]) begin
        hi_run[i] = hi_run[i] + 1;
      end else begin
        if (armed[i] && hi_run[i] != 0) begin
          n_cmp++;
          if (hi_run[i] != half_of(i)) begin
            n_bad++;
            $display("FAIL R3 lane %0d high width actual=%0d expected=%0d",
                     i, hi_run[i], half_of(i));
          end
        end
        hi_run[i] = 0;
        armed[i]  = 1'b1;
      end
    end

  // Scoreboard monitor: pops expectations and observes one window.
  initial begin : mon
    exp_t e;
    logic [NL-1:0] rose, hi, prv;
    logic [1:0] srose, shi, sprv;
    bit oe_ok, osc_ok;
    forever begin
      while (sb.size() == 0) @(negedge clk);
      e = sb.pop_front();
      rose = '0; hi = '0; srose = '0; shi = '0;
      prv = clk_out; sprv = shr_out; oe_ok = 1'b1; osc_ok = 1'b1;
      for (int c = 0; c < WIN; c++) begin
        @(negedge clk);
        rose  = rose | (clk_out & ~prv);
        hi    = hi | clk_out;
        srose = srose | (shr_out & ~sprv);
        shi   = shi | shr_out;
        prv = clk_out; sprv = shr_out;
        if (shr_oe !== e.oe) oe_ok = 1'b0;
        if (osc_on !== e.osc) osc_ok = 1'b0;
      end
      check((rose == e.run) && ((hi & ~e.run) == '0), {e.tag, " lanes"}, rose | hi, e.run);
      check((srose == e.srun) && ((shi & ~e.srun) == 2'b00), {e.tag, " shared out"},
            NL'(srose | shi), NL'(e.srun));
      check(oe_ok, {e.tag, " shared oe"}, NL'(shr_oe), NL'(e.oe));
      check(osc_ok, {e.tag, " osc_on"}, NL'(osc_on), NL'(e.osc));
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R3 watchdog actual=timeout expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : drv
    int low, maxlow;
    repeat (5) @(negedge clk);
    check(clk_out == '0, "R1 reset clk_out", clk_out, '0);
    check(shr_oe == 2'b00 && shr_out == 2'b00, "R1 reset shared pins", NL'({shr_oe, shr_out}), '0);
    check(osc_on == 1'b0, "R1 reset osc_on", NL'(osc_on), '0);
    @(negedge clk) rst_n = 1'b1;
    pulse_chk = 1'b1;

    settle_and_expect("R11 R5 default all lanes");
    shr_in = 2'b00;
    settle_and_expect("R5 stops ignored with strap high");
    strap = 1'b0; shr_in = 2'b11;
    settle_and_expect("R6 shared pins as inputs");
    shr_in = 2'b01;
    settle_and_expect("R7 cpu stop");
    shr_in = 2'b10;
    settle_and_expect("R8 pci stop keeps free lane");
    shr_in = 2'b00;
    settle_and_expect("R4 both stops");
    shr_in = 2'b11; lane_en = 25'h15A_C3E5;
    settle_and_expect("R4 enable pattern");
    shr_in = 2'b10; lane_en = 25'h0F0_F0F3;
    settle_and_expect("R4 enable and pci stop");
    strap = 1'b1; shr_in = 2'b11; lane_en = 25'h1FF_0F00;
    settle_and_expect("R2 stopped lanes held low");
    lane_en = '1;
    settle_and_expect("R2 R3 restart all lanes");

    pulse_chk = 1'b0; pwr_n = 1'b0;
    settle_and_expect("R9 power down");
    pwr_n = 1'b1;
    repeat (10) @(negedge clk);
    pulse_chk = 1'b1;
    settle_and_expect("R9 resume after power down");

    // R10: a one-cycle enable dip must give a full stop, then a restart.
    @(negedge clk) lane_en[0] = 1'b0;
    @(negedge clk) lane_en[0] = 1'b1;
    low = 0; maxlow = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (!clk_out[0]) begin
        low++;
        if (low > maxlow) maxlow = low;
      end else low = 0;
    end
    check(maxlow > 2, "R10 low gap after enable dip (min 3)", NL'(maxlow), NL'(3));
    settle_and_expect("R10 lane resumes after dip");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule